// File: doc/BRIEF.md
# Bus-Width Access Splitter

This block sits between a host port and a memory-access engine that drives an asynchronous flash-style device. The device data port is configured as 8 or 16 bits. The host issues one transfer of 8, 16 or 32 bits. The block breaks that transfer into as many narrow memory accesses as the port width requires and hands them to the engine one at a time. Each access uses a request/done handshake. On reads, the block packs the returned pieces back into a single host word.

Not every size combination is legal. A byte read from a 16-bit port is served by a single halfword access, and the wanted byte is picked out of that halfword. A byte write to a 16-bit port cannot be carried out, so it is refused with an error response and never reaches memory. All accesses are single and asynchronous, with no burst mode. Command, address and checksum sequencing of the flash device, and pin-level timing, belong to the engine and to blocks further down the chain.

Top module: `bus_split_top`

## Requirements
- R1: While reset is high and in the cycle after it is released, `host_ready`, `host_err` and `mem_req` are low.
- R2: With `mem_is16`=0, a transfer with `host_size` 0 (8 bits), 1 (16 bits) or 2 (32 bits) produces exactly 1, 2 or 4 memory accesses respectively, for reads and for writes.
- R3: With `mem_is16`=1, a 16-bit transfer produces exactly one memory access and a 32-bit transfer produces exactly two, for reads and for writes.
- R4: With `mem_is16`=1, an 8-bit read produces one access at the even address `host_addr` with bit 0 cleared. The result takes `mem_rdata[7:0]` when `host_addr[0]`=0 and `mem_rdata[15:8]` when it is 1, and it is zero-extended into `host_rdata`.
- R5: An 8-bit write with `mem_is16`=1, or any request with `host_size`=3, is refused. In the next cycle `host_ready` and `host_err` are both high for one cycle, and `mem_req` stays low for the whole transfer.
- R6: Pieces are issued least-significant first. Piece i goes to `host_addr`+i on an 8-bit port, and to `{host_addr[ADDR_W-1:1],0}`+2i on a 16-bit port.
- R7: On writes, piece i drives `host_wdata[8i+7:8i]` on `mem_wdata[7:0]` with `mem_wdata[15:8]`=0 on an 8-bit port, and drives `host_wdata[16i+15:16i]` on a 16-bit port. `mem_we` is high.
- R8: On reads, piece i lands in byte lane i (8-bit port, taken from `mem_rdata[7:0]`, with `mem_rdata[15:8]` ignored) or in halfword lane i (16-bit port). `host_rdata` bits above the transfer size are zero.
- R9: `host_ready` stays low while accesses are outstanding. It is high for exactly one cycle, in the cycle after the last `mem_done` is sampled. `host_err` is low on a successful transfer, and the read data is valid in that same cycle.
- R10: `mem_req` rises in the cycle after a legal request is accepted. It stays high, with `mem_addr` and `mem_we` steady, until `mem_done` is sampled. It stays high across pieces and falls after the last one.
- R11: A `host_req` that arrives while a transfer is in progress is ignored. It does not change addresses or data, and it does not start another transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_is16 | input | 1 | Memory port width: 0 = 8 bits, 1 = 16 bits; sampled when a request is accepted |
| host_req | input | 1 | Host request strobe, accepted when the block is idle |
| host_addr | input | ADDR_W | Host byte address |
| host_size | input | 2 | Transfer size: 0 = 8, 1 = 16, 2 = 32 bits, 3 = reserved |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Refusal flag, valid with `host_ready` |
| host_rdata | output | 32 | Assembled read data, valid with `host_ready` |
| mem_req | output | 1 | Access request to the memory engine |
| mem_addr | output | ADDR_W | Byte address of the current piece |
| mem_we | output | 1 | Direction of the current piece |
| mem_wdata | output | 16 | Write data of the current piece |
| mem_done | input | 1 | Engine completion of the current piece |
| mem_rdata | input | 16 | Engine read data, valid with `mem_done` |

## Verification
A wrong piece counter or a wrong latched size shows up as an access count that differs from R2/R3. That error appears at the latest when `host_ready` comes one piece early or late, and the bench flags it on the very cycle `mem_req` or `host_ready` disagrees with the model. A bad address step or a wrong lane index is visible on `mem_addr`/`mem_wdata` in the first wrong piece. A read lane error is visible only in the single cycle `host_ready` is high, which is where the bench samples `host_rdata`. A refusal decode error exposes itself one cycle after the request, either as a missing error flag or as `mem_req` rising.

// File: rtl/bs_pkg.sv
package bs_pkg;

    localparam int HOST_W     = 32;
    localparam int PORT_W     = 16;
    localparam int NARROW_W   = 8;
    localparam int MAX_PIECES = HOST_W / NARROW_W;
    localparam int IDX_W      = $clog2(MAX_PIECES);
    localparam int CNT_W      = IDX_W + 1;
    localparam int BYTE_LANES = HOST_W / NARROW_W;
    localparam int HALF_LANES = HOST_W / PORT_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RESP = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             legal;
        logic [CNT_W-1:0] pieces;
    } xfer_plan_t;

    typedef struct packed {
        xfer_size_e size;
        logic       we;
        logic       wide;
        logic       byte_hi;
    } xfer_ctx_t;

    function automatic logic [CNT_W-1:0] piece_count(xfer_size_e sz, logic wide);
        logic [CNT_W-1:0] n;
        case (sz)
            SZ_BYTE: n = CNT_W'(1);
            SZ_HALF: n = wide ? CNT_W'(1) : CNT_W'(2);
            SZ_WORD: n = wide ? CNT_W'(2) : CNT_W'(4);
            default: n = CNT_W'(0);
        endcase
        return n;
    endfunction

    function automatic logic size_legal(xfer_size_e sz, logic we, logic wide);
        logic ok;
        ok = (sz != SZ_RSVD);
        if (wide && we && sz == SZ_BYTE)
            ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/bs_plan.sv
module bs_plan
    import bs_pkg::*;
(
    input  xfer_size_e size,
    input  logic       we,
    input  logic       wide,
    output xfer_plan_t plan
);

    always_comb begin
        plan.legal  = size_legal(size, we, wide);
        plan.pieces = plan.legal ? piece_count(size, wide) : '0;
    end

    always_comb begin
        if (plan.legal)
            assert (plan.pieces != '0)
                else $error("p_legal_has_pieces_r2: legal plan with zero pieces");
        if (wide && we && size == SZ_BYTE)
            assert (!plan.legal)
                else $error("p_byte_wr16_refused_r5: narrow write on wide port accepted");
    end

endmodule

// File: rtl/bs_seq.sv
module bs_seq
    import bs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    input  xfer_size_e        host_size,
    input  logic              host_we,
    input  logic              mem_is16,
    input  xfer_plan_t        plan,
    input  logic              mem_done,
    output logic              accept,
    output logic              capture,
    output logic [IDX_W-1:0]  idx,
    output xfer_ctx_t         ctx,
    output logic              host_ready,
    output logic              host_err,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we
);

    seq_state_e        state;
    logic [CNT_W-1:0]  npieces;
    logic [ADDR_W-1:0] cur_addr;
    logic              err_q;
    logic              last_piece;
    logic [ADDR_W-1:0] step;

    assign accept     = (state == ST_IDLE) && host_req;
    assign capture    = (state == ST_RUN) && mem_done;
    assign last_piece = ({1'b0, idx} == (npieces - CNT_W'(1)));
    assign step       = ctx.wide ? ADDR_W'(2) : ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            npieces  <= '0;
            cur_addr <= '0;
            err_q    <= 1'b0;
            idx      <= '0;
            ctx      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (host_req) begin
                        ctx.size    <= host_size;
                        ctx.we      <= host_we;
                        ctx.wide    <= mem_is16;
                        ctx.byte_hi <= host_addr[0];
                        npieces     <= plan.pieces;
                        idx         <= '0;
                        err_q       <= !plan.legal;
                        cur_addr    <= mem_is16 ? {host_addr[ADDR_W-1:1], 1'b0} : host_addr;
                        state       <= plan.legal ? ST_RUN : ST_RESP;
                    end
                end
                ST_RUN: begin
                    if (mem_done) begin
                        if (last_piece) begin
                            state <= ST_RESP;
                        end else begin
                            idx      <= idx + IDX_W'(1);
                            cur_addr <= cur_addr + step;
                        end
                    end
                end
                ST_RESP: begin
                    state <= ST_IDLE;
                    err_q <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign host_ready = (state == ST_RESP);
    assign host_err   = (state == ST_RESP) && err_q;
    assign mem_req    = (state == ST_RUN);
    assign mem_addr   = cur_addr;
    assign mem_we     = ctx.we;

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);

    p_err_no_mem_r5: assert property (@(posedge clk) disable iff (rst)
        host_err |-> (host_ready && !mem_req));

    p_req_held_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_addr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req && mem_done)) |-> (mem_addr == $past(mem_addr) + step));

    p_no_narrow_wr_wide_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !(mem_we && ctx.wide && ctx.size == SZ_BYTE));

    p_idx_bound_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ({1'b0, idx} < npieces));

endmodule

// File: rtl/bs_pack.sv
module bs_pack
    import bs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic               capture,
    input  logic [IDX_W-1:0]   idx,
    input  xfer_ctx_t          ctx,
    input  logic               resp,
    input  logic [HOST_W-1:0]  host_wdata,
    input  logic [PORT_W-1:0]  mem_rdata,
    output logic [PORT_W-1:0]  mem_wdata,
    output logic [HOST_W-1:0]  host_rdata
);

    logic [HOST_W-1:0]   wdata_q;
    logic [HOST_W-1:0]   rdata_q;
    logic [NARROW_W-1:0] wbyte [BYTE_LANES];
    logic [PORT_W-1:0]   whalf [HALF_LANES];

    for (genvar b = 0; b < BYTE_LANES; b++) begin : g_wbyte
        assign wbyte[b] = wdata_q[b*NARROW_W +: NARROW_W];
    end
    for (genvar h = 0; h < HALF_LANES; h++) begin : g_whalf
        assign whalf[h] = wdata_q[h*PORT_W +: PORT_W];
    end

    assign mem_wdata = ctx.wide ? whalf[idx[0]] : {{(PORT_W-NARROW_W){1'b0}}, wbyte[idx]};

    logic [NARROW_W-1:0] sel_byte;
    assign sel_byte = ctx.byte_hi ? mem_rdata[PORT_W-1:NARROW_W] : mem_rdata[NARROW_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            wdata_q <= host_wdata;
            rdata_q <= '0;
        end else if (capture && !ctx.we) begin
            if (ctx.wide && ctx.size == SZ_BYTE) begin
                rdata_q[NARROW_W-1:0] <= sel_byte;
            end else if (ctx.wide) begin
                for (int h = 0; h < HALF_LANES; h++)
                    if (idx[0] == h[0])
                        rdata_q[h*PORT_W +: PORT_W] <= mem_rdata;
            end else begin
                for (int b = 0; b < BYTE_LANES; b++)
                    if (idx == b[IDX_W-1:0])
                        rdata_q[b*NARROW_W +: NARROW_W] <= mem_rdata[NARROW_W-1:0];
            end
        end
    end

    assign host_rdata = rdata_q;

    p_rdata_byte_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (resp && !ctx.we && ctx.size == SZ_BYTE) |-> (host_rdata[HOST_W-1:NARROW_W] == '0));

    p_rdata_half_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (resp && !ctx.we && ctx.size == SZ_HALF) |-> (host_rdata[HOST_W-1:PORT_W] == '0));

    p_wdata_narrow_r7: assert property (@(posedge clk) disable iff (rst)
        (capture && ctx.we && !ctx.wide) |-> (mem_wdata[PORT_W-1:NARROW_W] == '0));

endmodule

// File: rtl/bus_split_top.sv
module bus_split_top
    import bs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_is16,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic              host_we,
    input  logic [31:0]       host_wdata,
    output logic              host_ready,
    output logic              host_err,
    output logic [31:0]       host_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [15:0]       mem_wdata,
    input  logic              mem_done,
    input  logic [15:0]       mem_rdata
);

    xfer_size_e       size_in;
    xfer_plan_t       plan;
    xfer_ctx_t        ctx;
    logic             accept;
    logic             capture;
    logic [IDX_W-1:0] idx;

    assign size_in = xfer_size_e'(host_size);

    bs_plan u_plan (
        .size (size_in),
        .we   (host_we),
        .wide (mem_is16),
        .plan (plan)
    );

    bs_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_addr  (host_addr),
        .host_size  (size_in),
        .host_we    (host_we),
        .mem_is16   (mem_is16),
        .plan       (plan),
        .mem_done   (mem_done),
        .accept     (accept),
        .capture    (capture),
        .idx        (idx),
        .ctx        (ctx),
        .host_ready (host_ready),
        .host_err   (host_err),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we)
    );

    bs_pack u_pack (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .capture    (capture),
        .idx        (idx),
        .ctx        (ctx),
        .resp       (host_ready),
        .host_wdata (host_wdata),
        .mem_rdata  (mem_rdata),
        .mem_wdata  (mem_wdata),
        .host_rdata (host_rdata)
    );

endmodule

// File: tb/sim_bus_split_top.sv
module sim_bus_split_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_is16 = 1'b0;
    logic        host_req = 1'b0;
    logic [31:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, host_err;
    logic [31:0] host_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_done = 1'b0;
    logic [15:0] mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bus_split_top #(.ADDR_W(32)) u0 (
        .clk(clk), .rst(rst), .mem_is16(mem_is16),
        .host_req(host_req), .host_addr(host_addr), .host_size(host_size),
        .host_we(host_we), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_err(host_err), .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] rpiece(int i, int seed);
        return 16'h3C00 + 16'(i) * 16'h1357 + 16'(seed) * 16'h0101;
    endfunction

    // behavioural model of a whole transfer, compared every cycle
    task automatic run_xfer(input bit wide, input int size, input bit we,
                            input logic [31:0] addr, input logic [31:0] wd,
                            input int seed, input bit poke);
        int n;
        bit legal;
        int pieces_seen;
        logic [31:0] exp_rd;
        logic [31:0] exp_a;
        logic [15:0] exp_wd;
        legal = !(size == 3) && !(wide && we && size == 0);
        if (!legal) n = 0;
        else if (wide) n = (size == 2) ? 2 : 1;
        else n = 1 << size;
        exp_rd = '0;
        pieces_seen = 0;
        mem_is16 = wide;
        host_req = 1'b1;
        host_addr = addr;
        host_size = 2'(size);
        host_we = we;
        host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        host_wdata = ~wd;
        if (!legal) begin
            chk(host_ready == 1'b1, "R5 ready", 32'(host_ready), 32'd1);
            chk(host_err == 1'b1, "R5 err", 32'(host_err), 32'd1);
            chk(mem_req == 1'b0, "R5 no mem_req", 32'(mem_req), 32'd0);
            @(negedge clk);
            chk(host_ready == 1'b0 && host_err == 1'b0 && mem_req == 1'b0, "R5 one cycle",
                {29'd0, host_ready, host_err, mem_req}, 32'd0);
            return;
        end
        for (int i = 0; i < n; i++) begin
            int d;
            d = (i + seed) % 3;
            exp_a = wide ? ({addr[31:1], 1'b0} + 32'(2 * i)) : (addr + 32'(i));
            exp_wd = wide ? wd[16*i +: 16] : {8'h00, wd[8*i +: 8]};
            if (wide && size == 0)
                exp_rd[7:0] = addr[0] ? rpiece(i, seed)[15:8] : rpiece(i, seed)[7:0];
            else if (wide)
                exp_rd[16*i +: 16] = rpiece(i, seed);
            else
                exp_rd[8*i +: 8] = rpiece(i, seed)[7:0];
            for (int w = 0; w <= d; w++) begin
                chk(mem_req == 1'b1, "R10 mem_req held", 32'(mem_req), 32'd1);
                chk(host_ready == 1'b0, "R9 ready low while busy", 32'(host_ready), 32'd0);
                chk(mem_addr == exp_a, wide ? "R6 addr wide" : "R6 addr narrow", mem_addr, exp_a);
                chk(mem_we == we, "R10 mem_we", 32'(mem_we), 32'(we));
                if (we)
                    chk(mem_wdata == exp_wd, "R7 write piece", 32'(mem_wdata), 32'(exp_wd));
                if (w == d) begin
                    mem_done = 1'b1;
                    mem_rdata = rpiece(i, seed);
                    pieces_seen++;
                end else if (poke && i == 0 && w == 0) begin
                    host_req = 1'b1;
                    host_addr = addr ^ 32'h40;
                    host_size = 2'd2;
                end
                @(negedge clk);
                mem_done = 1'b0;
                host_req = 1'b0;
                mem_rdata = 16'hDEAD;
            end
        end
        chk(host_ready == 1'b1, wide ? "R3 count/ready" : "R2 count/ready", 32'(host_ready), 32'd1);
        chk(host_err == 1'b0, "R9 err low on success", 32'(host_err), 32'd0);
        chk(mem_req == 1'b0, "R10 mem_req falls", 32'(mem_req), 32'd0);
        chk(pieces_seen == n, "R2 pieces", 32'(pieces_seen), 32'(n));
        if (!we)
            chk(host_rdata == exp_rd, (wide && size == 0) ? "R4 byte select" : "R8 assembly",
                host_rdata, exp_rd);
        @(negedge clk);
        chk(host_ready == 1'b0, "R9 single pulse", 32'(host_ready), 32'd0);
        chk(mem_req == 1'b0, poke ? "R11 busy request ignored" : "R10 idle", 32'(mem_req), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(host_ready == 1'b0 && host_err == 1'b0 && mem_req == 1'b0, "R1 in reset",
            {29'd0, host_ready, host_err, mem_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(host_ready == 1'b0 && host_err == 1'b0 && mem_req == 1'b0, "R1 after reset",
            {29'd0, host_ready, host_err, mem_req}, 32'd0);

        // R2: narrow port, all sizes, both directions
        run_xfer(1'b0, 0, 1'b1, 32'h0000_1003, 32'hAABB_CC5A, 0, 1'b0);
        run_xfer(1'b0, 0, 1'b0, 32'h0000_1007, 32'h0, 1, 1'b0);
        run_xfer(1'b0, 1, 1'b1, 32'h0000_2010, 32'h1234_B7E1, 2, 1'b0);
        run_xfer(1'b0, 1, 1'b0, 32'h0000_2012, 32'h0, 0, 1'b0);
        run_xfer(1'b0, 2, 1'b1, 32'h0000_3000, 32'hCAFE_F00D, 1, 1'b0);
        run_xfer(1'b0, 2, 1'b0, 32'h0000_3104, 32'h0, 2, 1'b0);
        // R3: wide port
        run_xfer(1'b1, 1, 1'b1, 32'h0000_4002, 32'h5555_9ABC, 0, 1'b0);
        run_xfer(1'b1, 1, 1'b0, 32'h0000_4006, 32'h0, 1, 1'b0);
        run_xfer(1'b1, 2, 1'b1, 32'h0000_5008, 32'h8765_4321, 2, 1'b0);
        run_xfer(1'b1, 2, 1'b0, 32'h0000_500C, 32'h0, 0, 1'b0);
        // R4: byte read on wide port, both byte positions
        run_xfer(1'b1, 0, 1'b0, 32'h0000_6010, 32'h0, 1, 1'b0);
        run_xfer(1'b1, 0, 1'b0, 32'h0000_6011, 32'h0, 2, 1'b0);
        // R5: refusals
        run_xfer(1'b1, 0, 1'b1, 32'h0000_7001, 32'hFFFF_FFFF, 0, 1'b0);
        run_xfer(1'b0, 3, 1'b0, 32'h0000_7100, 32'h0, 0, 1'b0);
        run_xfer(1'b1, 3, 1'b1, 32'h0000_7200, 32'h0, 0, 1'b0);
        // refusal followed directly by a legal transfer
        run_xfer(1'b0, 1, 1'b0, 32'h0000_7300, 32'h0, 1, 1'b0);
        // R11: request while busy
        run_xfer(1'b0, 2, 1'b1, 32'h0000_8000, 32'h0F1E_2D3C, 1, 1'b1);
        run_xfer(1'b1, 2, 1'b0, 32'h0000_8100, 32'h0, 2, 1'b1);
        repeat (2) @(negedge clk);
        chk(mem_req == 1'b0 && host_ready == 1'b0, "R11 stays idle",
            {30'd0, mem_req, host_ready}, 32'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule